// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block keeps a 16-bit up-counter that advances once for every four cycles of its clock. The counter has no load path. It wraps from its maximum value back to zero. Other timer logic receives the full count on a parallel output, and a one-cycle pulse marks each wrap.

Software reads the count over a byte-wide read port as a high byte and a low byte. A read of the high byte first copies the low byte into a holding register. The later low-byte read returns that held value, so the two bytes always belong to the same count. A low-byte read with no high-byte read before it returns the live low byte. The count appears at two address pairs that alias each other. One holding register and one sequence flag serve both pairs.

Top module: `frc_timer`

## Requirements
- R1: While reset is asserted, `count_o` is 0xFFFC, `wrap_o` is 0, and no read sequence is open, so the first low-byte read after reset returns the live low byte.
- R2: After reset, `count_o` increases by exactly one every four clock cycles and holds its value in every other cycle.
- R3: The count wraps from 0xFFFF to 0x0000. `wrap_o` is 1 for exactly the one cycle in which the count first reads 0x0000.
- R4: Address bit 0 selects the byte (0 = high byte, 1 = low byte). Address bit 1 selects the alias pair (0 = primary, 1 = alternate). The two pairs return identical data.
- R5: A low-byte read with no sequence open returns bits 7:0 of the live count.
- R6: A high-byte read returns bits 15:8 of the live count. If no sequence is open, it also copies the live low byte into the holding register and opens a sequence.
- R7: A high-byte read while a sequence is open leaves the holding register unchanged.
- R8: A low-byte read while a sequence is open returns the holding register and closes the sequence. The next low-byte read returns the live low byte again.
- R9: A sequence opened by a high-byte read at one alias pair is completed by a low-byte read at the other pair.
- R10: A read strobe held high over several cycles is one access. Its latch or close takes effect only at the first clock edge of the strobe. The read data is 0 whenever the strobe is low.
- R11: The reset release is synchronized over two clock edges. The count stays at 0xFFFC until the prescaler has completed its first four-cycle period after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_en_i | input | 1 | Read strobe; side effects happen on its first active edge |
| rd_addr_i | input | 2 | Bit 0 selects the byte (0 high, 1 low); bit 1 selects the alias pair |
| rd_data_o | output | 8 | Read data, combinational from the strobe and address; 0 when idle |
| count_o | output | 16 | Live counter value |
| wrap_o | output | 1 | One-cycle pulse in the cycle the count first reads 0x0000 |

## Verification
The assertions check on every cycle that the prescaler tick is isolated and that the count holds between ticks. They also check that a wrap pulse only appears at a zero count, that a high-byte read opens a sequence and a low-byte read closes one, that the holding register stays fixed while a sequence is open, and that a strobe acts only once. Only the bench scenarios can show that the data on the bus matches the arithmetic count at the moment of each read. The same is true for the coherent pairing across aliases, the hidden effect of a long strobe on a later read, and the exact cycle of the wrap and of the first increment after reset.

// File: rtl/frc_pkg.sv
package frc_pkg;

  // Byte selected by address bit 0 of the read port
  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } byte_sel_e;

  // One decoded bus access
  typedef struct packed {
    logic      act;   // first edge of a strobe
    byte_sel_e sel;   // which byte is accessed
  } rd_req_t;

endpackage

// File: rtl/frc_prescale.sv
module frc_prescale #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q, phase_d;

  assign tick_o = (phase_q == PH_LAST);

  always_comb begin
    phase_d = phase_q + PH_W'(1);
    if (tick_o) phase_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  // R2: a tick never lasts more than one cycle
  a_r2_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/frc_count.sv
module frc_count #(
  parameter int              CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '1 - CNT_W'(3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (tick_i) begin
      cnt_d  = cnt_q + CNT_W'(1);
      wrap_d = (cnt_q == '1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RST_VAL;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R2: between ticks the count is frozen
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

  // R3: the wrap pulse only accompanies a zero count
  a_r3_wrap_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> (cnt_q == '0));

  // R3: the pulse is one cycle wide
  a_r3_wrap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |=> !wrap_q);

endmodule

// File: rtl/frc_rdport.sv
module frc_rdport
  import frc_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [BUS_W-1:0]  rd_data_o
);
  localparam int HI_LSB = CNT_W - BUS_W;

  logic             strobe_q;
  logic             open_q, open_d;
  logic [BUS_W-1:0] hold_q, hold_d;
  logic             hold_en;
  rd_req_t          req;
  logic [BUS_W-1:0] live_hi, live_lo;

  // Alias bits do not change the result: both pairs share all state
  logic unused_alias;
  assign unused_alias = ^rd_addr_i[ADDR_W-1:1];

  assign live_hi = cnt_i[HI_LSB +: BUS_W];
  assign live_lo = cnt_i[BUS_W-1:0];

  assign req.act = rd_en_i & ~strobe_q;
  assign req.sel = byte_sel_e'(rd_addr_i[0]);

  always_comb begin
    open_d  = open_q;
    hold_en = 1'b0;
    if (req.act) begin
      if (req.sel == SEL_HI) begin
        if (!open_q) begin
          hold_en = 1'b1;
          open_d  = 1'b1;
        end
      end else begin
        open_d = 1'b0;
      end
    end
    hold_d = hold_en ? live_lo : hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      open_q   <= 1'b0;
      hold_q   <= '0;
    end else begin
      strobe_q <= rd_en_i;
      open_q   <= open_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (req.sel == SEL_HI) rd_data_o = live_hi;
      else                   rd_data_o = open_q ? hold_q : live_lo;
    end
  end

  // R6: a high-byte access leaves a sequence open
  a_r6_hi_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req.act && req.sel == SEL_HI) |=> open_q);

  // R7: the holding register is frozen against repeated high-byte reads
  a_r7_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && !(req.act && req.sel == SEL_LO)) |=> $stable(hold_q));

  // R8: a low-byte access closes the sequence
  a_r8_lo_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req.act && req.sel == SEL_LO) |=> !open_q);

  // R10: one access per strobe
  a_r10_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req.act |=> !req.act);

endmodule

// File: rtl/frc_timer.sv
module frc_timer #(
  parameter int BUS_W     = 8,
  parameter int CNT_W     = 2 * BUS_W,
  parameter int ADDR_W    = 2,
  parameter int PRESCALE  = 4,
  parameter int SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o
);
  localparam logic [CNT_W-1:0] CNT_RST = '1 - CNT_W'(3);

  // Reset: asserted asynchronously, released through a short synchronizer
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STG-1];

  logic tick;

  frc_prescale #(.DIV(PRESCALE)) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_o (tick)
  );

  frc_count #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick),
    .cnt_o  (count_o),
    .wrap_o (wrap_o)
  );

  frc_rdport #(.BUS_W(BUS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rdport (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .cnt_i     (count_o),
    .rd_data_o (rd_data_o)
  );

  // R1: while reset is held the count sits at its defined start value
  a_r1_reset_value: assert property (@(posedge clk_i)
    !rst_n |=> (!rst_n || count_o == CNT_RST));

endmodule

// File: tb/frc_timer_tb_top.sv
`timescale 1ns/1ps
module frc_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n_tb;
  logic       rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic [15:0] count;
  logic       wrap;

  int  edges = 0;
  int  checks = 0;
  int  fails = 0;
  bit  done = 0;
  bit  m_open = 0;
  logic [7:0] m_hold = '0;

  always #2 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  frc_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n_tb), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .count_o(count), .wrap_o(wrap)
  );

  function automatic logic [15:0] exp_cnt(input int e);
    int eff = e - 2;
    if (eff < 0) eff = 0;
    return 16'(32'hFFFC + eff / 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n_tb = 1'b0; rd_en = 1'b0; rd_addr = 2'd0;
    @(negedge clk); @(negedge clk); #1;
    check("R1 count", count, 32'hFFFC);
    check("R1 wrap", wrap, 0);
    @(negedge clk); rst_n_tb = 1'b1; edges = 0;
    m_open = 0;
  endtask

  // Single-cycle read; model updates as the edge after it will
  task automatic rd(input logic [1:0] a, input string req);
    logic [15:0] cur;
    logic [7:0]  expd;
    @(negedge clk); rd_en = 1'b1; rd_addr = a; #1;
    cur = exp_cnt(edges);
    if (a[0] == 1'b0) begin
      expd = cur[15:8];
      if (!m_open) begin m_hold = cur[7:0]; m_open = 1; end
    end else begin
      expd = m_open ? m_hold : cur[7:0];
      m_open = 0;
    end
    check(req, rd_data, expd);
    @(negedge clk); rd_en = 1'b0; #1;
    check("R10 idle data", rd_data, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rd_en = 1'b0; rd_addr = '0; rst_n_tb = 1'b0;
    do_reset();

    // R11 / R2 / R3: sweep count and wrap pulse against arithmetic
    for (int i = 0; i < 1200; i++) begin
      #1;
      if (edges < 6) check("R11 start delay", count, exp_cnt(edges));
      else           check("R2 count", count, exp_cnt(edges));
      check("R3 wrap", wrap,
            (edges >= 1 && exp_cnt(edges) == 16'h0 && exp_cnt(edges - 1) == 16'hFFFF));
      @(negedge clk);
    end

    // R5: low byte only, both aliases
    rd(2'd1, "R5 live low primary");
    idle(3);
    rd(2'd3, "R5 live low alternate");

    // R6 + R8: coherent pair on primary
    rd(2'd0, "R6 high primary");
    idle(9);
    rd(2'd1, "R8 held low primary");
    rd(2'd1, "R8 live low after close");

    // R7: repeated high reads keep the first held value
    rd(2'd2, "R6 high alternate");
    idle(5);
    rd(2'd2, "R7 repeat high");
    idle(7);
    rd(2'd0, "R7 repeat high other alias");
    idle(3);
    rd(2'd3, "R7 held low after repeats");

    // R9: cross-alias completion
    rd(2'd2, "R9 high alternate");
    idle(6);
    rd(2'd1, "R9 low primary");
    rd(2'd0, "R9 high primary");
    idle(6);
    rd(2'd3, "R9 low alternate");

    // R10: strobe held across high then low address acts once
    begin
      logic [15:0] cur;
      logic [7:0] h;
      @(negedge clk); rd_en = 1'b1; rd_addr = 2'd0; #1;
      cur = exp_cnt(edges); h = cur[7:0];
      check("R10 held strobe high", rd_data, cur[15:8]);
      m_hold = h; m_open = 1;
      @(negedge clk); rd_addr = 2'd1; #1;
      check("R10 held strobe low data", rd_data, h);
      @(negedge clk); rd_addr = 2'd3; #1;
      check("R10 held strobe still held", rd_data, h);
      @(negedge clk); rd_en = 1'b0; #1;
      check("R10 idle data", rd_data, 0);
      idle(5);
      rd(2'd1, "R10 sequence still open after long strobe");
    end

    // R4: near-exhaustive address pattern sweep with aliasing
    for (int i = 0; i < 256; i++) begin
      logic [1:0] a;
      a = 2'((i ^ (i >> 2) ^ (i >> 5)) & 3);
      rd(a, a[1] ? "R4 alternate pair" : "R4 primary pair");
      idle(i % 5);
    end

    // R1: reset cancels an open sequence
    rd(2'd0, "R6 high before reset");
    do_reset();
    idle(3);
    rd(2'd1, "R1 live low after reset");
    #1;
    check("R11 count after reset", count, exp_cnt(edges));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule